// File: doc/BRIEF.md
# Key-Sequence Watchdog Timer

This block is a watchdog for a small microcontroller core. It sits on the core's register write bus (address, data and a write strobe) and takes the machine-cycle tick, the idle and power-down status, a control bit that stops the count in idle, and the level of the interrupt line that wakes the core from power-down. Its only output is a reset request pulse.

The watchdog comes out of reset disarmed. Software arms it by writing a two-byte key to one write-only service address: first 8'h1E, then 8'hE1. The same two-byte key, written while armed, clears the hidden counter. Nothing else disarms it: only the hardware reset or its own overflow does. Once armed, the counter advances on every machine-cycle tick. It holds still in power-down and in idle when the idle-stop bit is set. After an interrupt wake-up, the count stays suspended until the wake line is high again. When the counter runs out, the block raises its reset output for a fixed number of clock periods, and it is disarmed and cleared at the same moment.

Top module: `keyed_watchdog`

## Requirements
- R1: After `rst_ni` is released, `rst_out_o` is low and stays low for as long as the watchdog has not been armed, however many ticks arrive.
- R2: Writing 8'h1E and then 8'hE1 to address 8'hA6, with the second write being the next write to that address, arms the watchdog. Writes to any other address do not disturb a key sequence in progress.
- R3: After 8'h1E, any write to 8'hA6 of a value other than 8'hE1 cancels the sequence, so a later 8'hE1 alone does not arm. A second 8'h1E restarts it, so the order 1E, 1E, E1 arms.
- R4: While armed, the 14-bit counter advances once per clock edge that has `tick_i` high. The overflow happens on the 16383rd counted tick after the arming edge, and `rst_out_o` rises right after that edge.
- R5: The key sequence written while armed clears the counter to zero. The next overflow then comes a full 16383 counted ticks after the clearing edge. A clear and a tick on the same edge leave the counter at zero.
- R6: Once armed, no write on the bus disarms the watchdog, whatever its address or value.
- R7: On overflow, `rst_out_o` is high for exactly 98 consecutive clock cycles. An overflow that arrives while the pulse is running does not restart it.
- R8: The overflow disarms the watchdog and clears its counter, so no further pulse follows unless software arms it again.
- R9: While `pdown_i` is high, the counter holds its value.
- R10: After power-down ends, the counter stays frozen while `wake_irq_ni` is low. The first edge on which it is seen high is still frozen, and counting resumes on the edge after that.
- R11: In idle (`idle_i` high), the counter keeps counting when `idle_stop_i` is 0 and holds its value when `idle_stop_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous hardware reset, active low |
| tick_i | input | 1 | Machine-cycle tick, one clock wide |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| idle_i | input | 1 | Core is in idle mode |
| idle_stop_i | input | 1 | 1 = freeze the count during idle |
| pdown_i | input | 1 | Core is in power-down |
| wake_irq_ni | input | 1 | Level of the wake interrupt line, active low |
| rst_out_o | output | 1 | Reset request pulse |

## Verification
The hardest situation to reach from the ports is the wake-up hold-off. The counter cannot be observed, so a frozen interval shows only as a shift in the moment the overflow fires, many thousands of cycles later. The stimulus arms the watchdog and lets it count part of the way. It then enters power-down, drops the wake line, leaves power-down with the line still low and finally releases it. The bench compares the overflow edge against an exact count that includes the single dead edge. The idle-stop path is reached the same way: the count is frozen for a long stretch and must then restart from zero.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // progress through the two-byte service key
   typedef enum logic {
      KEY_WAIT_FIRST  = 1'b0,
      KEY_WAIT_SECOND = 1'b1
   } key_state_e;

endpackage

// File: rtl/wdt_key_detect.sv
module wdt_key_detect #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR   = 8'hA6,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic              kick_o
);
   import wdt_pkg::*;

   key_state_e state_q, state_d;
   logic       svc_wr;

   assign svc_wr = wr_en_i && (wr_addr_i == SVC_ADDR);
   assign kick_o = svc_wr && (wr_data_i == KEY_SECOND) && (state_q == KEY_WAIT_SECOND);

   always_comb begin
      state_d = state_q;
      if (svc_wr) begin
         state_d = (wr_data_i == KEY_FIRST) ? KEY_WAIT_SECOND : KEY_WAIT_FIRST;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) state_q <= KEY_WAIT_FIRST;
      else         state_q <= state_d;
   end
endmodule

// File: rtl/wdt_count_core.sv
module wdt_count_core #(
   parameter int CNT_W      = 14,
   parameter int WAKE_SYNC  = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic kick_i,
   input  logic tick_i,
   input  logic idle_i,
   input  logic idle_stop_i,
   input  logic pdown_i,
   input  logic wake_irq_ni,
   output logic ovf_o
);
   localparam logic [CNT_W-1:0] LAST_STEP = {{(CNT_W-1){1'b1}}, 1'b0};

   logic             en_q;
   logic [CNT_W-1:0] cnt_q;
   logic             hold_q;
   logic             wake_s;
   logic             step;

   generate
      if (WAKE_SYNC == 0) begin : g_wake_direct
         assign wake_s = wake_irq_ni;
      end else begin : g_wake_sync
         logic [WAKE_SYNC-1:0] sync_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
               sync_q <= '1;
            end else begin
               sync_q[0] <= wake_irq_ni;
               for (int i = 1; i < WAKE_SYNC; i++) sync_q[i] <= sync_q[i-1];
            end
         end
         assign wake_s = sync_q[WAKE_SYNC-1];
      end
   endgenerate

   assign step  = en_q && tick_i && !pdown_i && !hold_q && !(idle_i && idle_stop_i);
   assign ovf_o = step && !kick_i && (cnt_q == LAST_STEP);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (kick_i) begin
         en_q  <= 1'b1;
         cnt_q <= '0;
      end else if (ovf_o) begin
         en_q  <= 1'b0;
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   // suspended from power-down entry until the wake line is seen high
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hold_q <= 1'b0;
      else         hold_q <= pdown_i || (hold_q && !wake_s);
   end
endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
   parameter int PULSE_LEN = 98
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ovf_i,
   output logic pulse_o
);
   localparam int PW = $clog2(PULSE_LEN + 1);
   localparam logic [PW-1:0] LOAD = PW'(PULSE_LEN);

   logic [PW-1:0] left_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          left_q <= '0;
      else if (ovf_i && (left_q == '0))     left_q <= LOAD;
      else if (left_q != '0)                left_q <= left_q - 1'b1;
   end

   assign pulse_o = (left_q != '0);
endmodule

// File: rtl/keyed_watchdog.sv
module keyed_watchdog #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR   = 8'hA6,
   parameter logic [DATA_W-1:0] KEY_FIRST  = 8'h1E,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1,
   parameter int                CNT_W      = 14,
   parameter int                PULSE_LEN  = 98,
   parameter int                WAKE_SYNC  = 0
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] wr_addr_i,
   input  logic [DATA_W-1:0] wr_data_i,
   input  logic              idle_i,
   input  logic              idle_stop_i,
   input  logic              pdown_i,
   input  logic              wake_irq_ni,
   output logic              rst_out_o
);
   generate
      if (CNT_W < 2) begin : g_bad_cnt
         $error("keyed_watchdog: CNT_W must be at least 2");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("keyed_watchdog: PULSE_LEN must be at least 1");
      end
      if (KEY_FIRST == KEY_SECOND) begin : g_bad_key
         $error("keyed_watchdog: the two key bytes must differ");
      end
      if (WAKE_SYNC < 0) begin : g_bad_sync
         $error("keyed_watchdog: WAKE_SYNC must not be negative");
      end
   endgenerate

   logic kick;
   logic ovf;

   wdt_key_detect #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
      .KEY_FIRST(KEY_FIRST), .KEY_SECOND(KEY_SECOND)
   ) u_key (
      .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
      .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .kick_o(kick)
   );

   wdt_count_core #(.CNT_W(CNT_W), .WAKE_SYNC(WAKE_SYNC)) u_core (
      .clk_i(clk_i), .rst_ni(rst_ni), .kick_i(kick), .tick_i(tick_i),
      .idle_i(idle_i), .idle_stop_i(idle_stop_i), .pdown_i(pdown_i),
      .wake_irq_ni(wake_irq_ni), .ovf_o(ovf)
   );

   wdt_pulse_gen #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk_i(clk_i), .rst_ni(rst_ni), .ovf_i(ovf), .pulse_o(rst_out_o)
   );
endmodule

// File: rtl/keyed_watchdog_chk.sv
module keyed_watchdog_chk #(
   parameter int                ADDR_W     = 8,
   parameter int                DATA_W     = 8,
   parameter logic [ADDR_W-1:0] SVC_ADDR   = 8'hA6,
   parameter logic [DATA_W-1:0] KEY_SECOND = 8'hE1,
   parameter int                CNT_W      = 14,
   parameter int                PULSE_LEN  = 98
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              wr_en_i,
   input logic [ADDR_W-1:0] wr_addr_i,
   input logic [DATA_W-1:0] wr_data_i,
   input logic              idle_i,
   input logic              idle_stop_i,
   input logic              pdown_i,
   input logic              rst_out_o,
   input logic              en,
   input logic [CNT_W-1:0]  cnt
);
   localparam int HW = $clog2(PULSE_LEN + 2);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [HW-1:0] high_run_q;
   logic          svc_wr;

   assign svc_wr = wr_en_i && (wr_addr_i == SVC_ADDR);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        high_run_q <= '0;
      else if (rst_out_o) high_run_q <= high_run_q + 1'b1;
      else                high_run_q <= '0;
   end

   // R1
   pulse_needs_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_out_o) |-> $past(en));

   // R2
   arm_by_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(en) |-> $past(svc_wr && (wr_data_i == KEY_SECOND)));

   // R4
   count_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (cnt != $past(cnt)) |-> ((cnt == $past(cnt) + ONE) || (cnt == '0)));

   // R6
   disarm_only_ovf_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(en) |-> $rose(rst_out_o));

   // R7
   pulse_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_out_o |-> (int'(high_run_q) < PULSE_LEN));

   // R7
   pulse_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rst_out_o) |-> (int'(high_run_q) == PULSE_LEN));

   // R8
   ovf_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rst_out_o) |-> (!en && (cnt == '0)));

   // R9
   pdown_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (pdown_i && !svc_wr) |=> $stable(cnt));

   // R11
   idle_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle_i && idle_stop_i && !svc_wr) |=> $stable(cnt));
endmodule

bind keyed_watchdog keyed_watchdog_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SVC_ADDR(SVC_ADDR),
   .KEY_SECOND(KEY_SECOND), .CNT_W(CNT_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
   .wr_data_i(wr_data_i), .idle_i(idle_i), .idle_stop_i(idle_stop_i),
   .pdown_i(pdown_i), .rst_out_o(rst_out_o),
   .en(u_core.en_q), .cnt(u_core.cnt_q)
);

// File: tb/sim_keyed_watchdog.sv
module sim_keyed_watchdog;
   localparam int CNT_W     = 14;
   localparam int PULSE     = 98;
   localparam int OVF_TICKS = (1 << CNT_W) - 1;
   localparam int LIMIT     = 195000;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b1;
   logic       wr_en = 1'b0;
   logic [7:0] wr_addr = 8'h00;
   logic [7:0] wr_data = 8'h00;
   logic       idle = 1'b0;
   logic       idle_stop = 1'b0;
   logic       pdown = 1'b0;
   logic       wake_n = 1'b1;
   logic       rst_out;

   int checks = 0;
   int fails  = 0;

   always #5 clk = ~clk;

   keyed_watchdog u0 (
      .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .wr_en_i(wr_en),
      .wr_addr_i(wr_addr), .wr_data_i(wr_data), .idle_i(idle),
      .idle_stop_i(idle_stop), .pdown_i(pdown), .wake_irq_ni(wake_n),
      .rst_out_o(rst_out)
   );

   // behavioural reference, advanced on every clock edge
   bit m_en, m_first, m_hold;
   int m_cnt, m_left;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_en = 0; m_first = 0; m_hold = 0; m_cnt = 0; m_left = 0;
      end else begin
         bit svc, kick, step, ovf;
         svc  = wr_en && (wr_addr == 8'hA6);
         kick = svc && (wr_data == 8'hE1) && m_first;
         step = m_en && tick && !pdown && !m_hold && !(idle && idle_stop);
         ovf  = step && !kick && (m_cnt + 1 == OVF_TICKS);
         if (svc) m_first = (wr_data == 8'h1E);
         if (m_left > 0) m_left = m_left - 1;
         else if (ovf) m_left = PULSE;
         if (kick) begin m_en = 1; m_cnt = 0; end
         else if (ovf) begin m_en = 0; m_cnt = 0; end
         else if (step) m_cnt = m_cnt + 1;
         m_hold = pdown || (m_hold && !wake_n);
      end
   end

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) check(rst_out == (m_left != 0), "R7 cycle model of rst_out_o", rst_out, int'(m_left != 0));
   end

   task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_pulse(input int lim, output int n, output bit seen);
      n = 0; seen = 0;
      while (n < lim && !seen) begin
         @(negedge clk);
         n++;
         if (rst_out) seen = 1;
      end
   endtask

   task automatic pulse_width(output int w);
      w = 1;
      forever begin
         @(negedge clk);
         if (!rst_out) break;
         w++;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   endtask

   initial begin
      repeat (LIMIT) @(posedge clk);
      checks++; fails++;
      $display("FAIL watchdog on R1 through R11 actual=%0d expected=finished", LIMIT);
      summary();
   end

   initial begin
      int n, w;
      bit seen;
      run(3);
      rst_n = 1'b1;
      check(rst_out == 1'b0, "R1 reset value of rst_out_o", rst_out, 0);

      // R1: never armed, no pulse
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(!seen, "R1 no pulse while disarmed", seen, 0);

      // R3: broken sequence does not arm
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'h55);
      sfr_write(8'hA6, 8'hE1);
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(!seen, "R3 broken key leaves watchdog disarmed", seen, 0);

      // R2: write to another address between the key bytes
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA5, 8'hE1);
      sfr_write(8'hA6, 8'hE1);
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(seen, "R2 key arms the watchdog", seen, 1);
      check(n == OVF_TICKS, "R4 overflow edge after arming", n, OVF_TICKS);
      pulse_width(w);
      check(w == PULSE, "R7 reset pulse width", w, PULSE);
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(!seen, "R8 overflow disarms", seen, 0);

      // R3 restart, R6 cannot disarm, R5 service
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'hE1);
      sfr_write(8'hA6, 8'h00);
      sfr_write(8'hA6, 8'hFF);
      sfr_write(8'h10, 8'h00);
      run(12000);
      check(rst_out == 1'b0, "R6 still counting, no pulse yet", rst_out, 0);
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'hE1);
      run(12000);
      check(rst_out == 1'b0, "R5 service delayed the overflow", rst_out, 0);
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'hE1);
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(seen, "R6 watchdog stayed armed", seen, 1);
      check(n == OVF_TICKS, "R5 full period after service", n, OVF_TICKS);
      pulse_width(w);
      check(w == PULSE, "R7 second pulse width", w, PULSE);

      // R9 and R10: power-down and wake hold-off
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'hE1);
      run(5000);
      pdown = 1'b1;
      run(3000);
      check(rst_out == 1'b0, "R9 no pulse in power-down", rst_out, 0);
      wake_n = 1'b0;
      run(100);
      pdown = 1'b0;
      run(400);
      check(rst_out == 1'b0, "R10 hold-off while wake line low", rst_out, 0);
      wake_n = 1'b1;
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(n == OVF_TICKS - 5000 + 1, "R10 resume one edge after wake high", n, OVF_TICKS - 5000 + 1);
      pulse_width(w);

      // R11: idle with and without the stop bit
      sfr_write(8'hA6, 8'h1E);
      sfr_write(8'hA6, 8'hE1);
      idle = 1'b1;
      idle_stop = 1'b1;
      wait_pulse(5000, n, seen);
      check(!seen, "R11 frozen in idle with stop bit", seen, 0);
      idle_stop = 1'b0;
      wait_pulse(OVF_TICKS + 200, n, seen);
      check(n == OVF_TICKS, "R11 counts in idle without stop bit", n, OVF_TICKS);
      idle = 1'b0;
      pulse_width(w);
      check(w == PULSE, "R7 pulse width after idle", w, PULSE);

      run(5);
      summary();
   end
endmodule